// File: doc/BRIEF.md
# Flit Receive Retry Controller

This block sits on the receive side of a flit-based link, after error correction. Each incoming flit carries a 10-bit sequence number and a single flag saying whether its CRC check came out clean. The block hands clean flits to the layer above strictly in sequence order, with no gaps and no repeats. When a flit fails its CRC, the block asks the link partner for a retransmission and makes no attempt to find or fix the error. The whole flit is the unit of retry.

Two recovery styles are supported, and `cfgSelective` chooses between them at the moment of failure. In selective recovery only the missing flit is requested again. Clean flits that follow it are parked in a small hold store, then released one per cycle right behind the replayed flit. In go-back-N recovery the request asks the partner to resend everything from the missing flit onwards, and anything that arrives meanwhile is discarded. The block falls back from selective to go-back-N in two cases: when the hold store cannot take a flit, and when another CRC failure arrives while a recovery is pending. It reissues its request if the wanted flit does not show up within `cfgTimeout` cycles. The behaviour does not depend on the line rate.

Top module: `flit_replay_rx`

## Requirements
- R1: After reset `outValid` and `reqValid` are low, and the first sequence number the block expects, and so the first it delivers, is 0.
- R2: A clean flit whose sequence number equals the expected one is presented on `outSeq`/`outData` with `outValid` high in the cycle after it is accepted, and the expected number then advances by one modulo 1024.
- R3: A flit with `inCrcOk` low that arrives while no recovery is pending is never delivered. In the following cycle `reqValid` pulses with `reqSeq` set to the expected number and `reqSelective` equal to `cfgSelective` (1 = selective, 0 = go-back-N). The sequence field of a failed flit is ignored.
- R4: In selective recovery, clean flits 1 to DEPTH-1 ahead of the expected number are held. Once the replayed flit is delivered, the held flits follow in consecutive cycles, one per cycle, in sequence order.
- R5: In go-back-N recovery every flit other than the clean expected one is dropped. After the replayed flit is delivered, nothing else comes out until the next number arrives again.
- R6: A clean flit behind the expected number (an offset of 512 or more modulo 1024, wraparound included) or already held is discarded with no output and no request.
- R7: During selective recovery, a clean flit DEPTH or more ahead of the expected number empties the hold store. The block then requests the expected number with `reqSelective` = 0 and continues in go-back-N.
- R8: A CRC failure while a recovery is pending empties the hold store. The block then requests the expected number with `reqSelective` = 0.
- R9: While recovery is pending and nothing is delivered, the request is reissued for the same number and mode every `cfgTimeout` cycles (`cfgTimeout` at least 1).
- R10: A clean flit ahead of the expected number arriving with no recovery pending is taken as a lost flit. It causes a request as in R3 and produces no output.
- R11: Under any mix of CRC failures, modes and partner behaviour, delivered sequence numbers rise by exactly one from each delivery to the next, and each carries its own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cfgSelective | input | 1 | Recovery style for a new failure: 1 selective, 0 go-back-N |
| cfgTimeout | input | TMO_W | Cycles without the wanted flit before a request is reissued |
| inValid | input | 1 | A flit is present this cycle |
| inSeq | input | SEQ_W | Sequence number of the incoming flit |
| inCrcOk | input | 1 | CRC check of the incoming flit was clean |
| inData | input | FLIT_W | Flit payload |
| outValid | output | 1 | An in-order flit is delivered this cycle |
| outSeq | output | SEQ_W | Sequence number of the delivered flit |
| outData | output | FLIT_W | Payload of the delivered flit |
| reqValid | output | 1 | Retransmission request pulse |
| reqSeq | output | SEQ_W | Sequence number to resend (or to resend from) |
| reqSelective | output | 1 | 1: resend only that flit; 0: resend from it onwards |

## Verification
The hardest state to reach from the ports is a hold store draining its parked flits while new flits keep arriving and a further CRC failure or overflow lands in the middle of it. Directed tests walk through the store filling to its limit and a second failure during selective recovery, and they probe the timeout cycle by cycle. A closing random run drives a link-partner model with randomly delayed responses. That model answers selective requests late, so later flits pile up in the store, and it corrupts flits at random, including replayed ones. Every delivery is checked against the next expected number and its payload.

// File: rtl/flit_replay_pkg.sv
package flit_replay_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEL,
    ST_GBN
  } rxState_e;

  typedef struct packed {
    logic storeIn;
    logic popHead;
    logic passIn;
    logic flush;
    logic sendReq;
    logic reqSel;
  } strobe_t;

endpackage

// File: rtl/flit_replay_ctrl.sv
module flit_replay_ctrl
  import flit_replay_pkg::*;
#(
  parameter int SEQ_W = 10,
  parameter int DEPTH = 8,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [SEQ_W-1:0] inSeq,
  input  logic             inCrcOk,
  input  logic             cfgSelective,
  input  logic [TMO_W-1:0] cfgTimeout,
  input  logic [DEPTH-1:0] heldValid,
  output strobe_t          strobe,
  output logic [SEQ_W-1:0] expSeq,
  output logic [SEQ_W-1:0] reqSeqNext
);

  localparam int IDX_W = $clog2(DEPTH);

  rxState_e         st, stNext;
  strobe_t          s;
  logic [TMO_W-1:0] tmoCnt;
  logic [SEQ_W-1:0] offset, expNext;
  logic [IDX_W-1:0] headIdx, slotIdx;
  logic [DEPTH-1:0] remaining;
  logic             behind, isNext, inWin, headValid, slotValid, timeUp, delivered;

  assign offset    = inSeq - expSeq;
  assign behind    = offset[SEQ_W-1];
  assign isNext    = (offset == '0);
  assign inWin     = !behind && (offset < SEQ_W'(DEPTH));
  assign headIdx   = expSeq[IDX_W-1:0];
  assign slotIdx   = inSeq[IDX_W-1:0];
  assign headValid = heldValid[headIdx];
  assign slotValid = heldValid[slotIdx];
  assign timeUp    = (tmoCnt == cfgTimeout - TMO_W'(1));

  always_comb begin
    s         = '0;
    stNext    = st;
    s.popHead = headValid;
    if (inValid) begin
      if (!inCrcOk) begin
        s.sendReq = 1'b1;
        if (st == ST_IDLE) begin
          s.reqSel = cfgSelective;
          stNext   = cfgSelective ? ST_SEL : ST_GBN;
        end else begin
          s.flush = 1'b1;
          stNext  = ST_GBN;
        end
      end else if (st == ST_GBN) begin
        if (isNext) begin
          s.passIn = 1'b1;
          stNext   = ST_IDLE;
        end
      end else if (behind) begin
        s.passIn = 1'b0;
      end else if (isNext) begin
        s.passIn = !headValid;
      end else if (st == ST_IDLE) begin
        s.sendReq = 1'b1;
        s.reqSel  = cfgSelective;
        s.storeIn = cfgSelective && inWin;
        stNext    = cfgSelective ? ST_SEL : ST_GBN;
      end else if (inWin) begin
        s.storeIn = !slotValid;
      end else begin
        s.sendReq = 1'b1;
        s.flush   = 1'b1;
        stNext    = ST_GBN;
      end
    end

    delivered = s.passIn | s.popHead;
    remaining = heldValid & ~(s.popHead ? (DEPTH'(1) << headIdx) : '0);
    if (st == ST_SEL && stNext == ST_SEL && delivered && remaining == '0 && !s.storeIn)
      stNext = ST_IDLE;

    if (st != ST_IDLE && stNext == st && !s.sendReq && !delivered && timeUp) begin
      s.sendReq = 1'b1;
      s.reqSel  = (st == ST_SEL);
    end

    expNext = expSeq + SEQ_W'(delivered);
  end

  assign strobe     = s;
  assign reqSeqNext = expNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st     <= ST_IDLE;
      expSeq <= '0;
      tmoCnt <= '0;
    end else begin
      st     <= stNext;
      expSeq <= expNext;
      if (s.sendReq || delivered || stNext == ST_IDLE) tmoCnt <= '0;
      else                                              tmoCnt <= tmoCnt + TMO_W'(1);
    end
  end

endmodule

// File: rtl/flit_replay_dp.sv
module flit_replay_dp
  import flit_replay_pkg::*;
#(
  parameter int SEQ_W  = 10,
  parameter int FLIT_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [SEQ_W-1:0]  inSeq,
  input  logic [FLIT_W-1:0] inData,
  input  logic [SEQ_W-1:0]  expSeq,
  input  logic [SEQ_W-1:0]  reqSeqNext,
  output logic [DEPTH-1:0]  heldValid,
  output logic              outValid,
  output logic [SEQ_W-1:0]  outSeq,
  output logic [FLIT_W-1:0] outData,
  output logic              reqValid,
  output logic [SEQ_W-1:0]  reqSeq,
  output logic              reqSelective
);

  localparam int IDX_W = $clog2(DEPTH);

  logic [FLIT_W-1:0] holdMem [DEPTH];
  logic [DEPTH-1:0]  slotWr, slotClr;
  logic [IDX_W-1:0]  headIdx, slotIdx;

  assign headIdx = expSeq[IDX_W-1:0];
  assign slotIdx = inSeq[IDX_W-1:0];

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    assign slotWr[g]  = strobe.storeIn && (slotIdx == IDX_W'(g));
    assign slotClr[g] = strobe.popHead && (headIdx == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++)
      if (slotWr[i]) holdMem[i] <= inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             heldValid <= '0;
    else if (strobe.flush) heldValid <= '0;
    else                   heldValid <= (heldValid & ~slotClr) | slotWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid     <= 1'b0;
      outSeq       <= '0;
      outData      <= '0;
      reqValid     <= 1'b0;
      reqSeq       <= '0;
      reqSelective <= 1'b0;
    end else begin
      outValid <= strobe.passIn | strobe.popHead;
      if (strobe.passIn | strobe.popHead) begin
        outSeq  <= expSeq;
        outData <= strobe.popHead ? holdMem[headIdx] : inData;
      end
      reqValid <= strobe.sendReq;
      if (strobe.sendReq) begin
        reqSeq       <= reqSeqNext;
        reqSelective <= strobe.reqSel;
      end
    end
  end

endmodule

// File: rtl/flit_replay_rx.sv
module flit_replay_rx
  import flit_replay_pkg::*;
#(
  parameter int SEQ_W  = 10,
  parameter int FLIT_W = 32,
  parameter int DEPTH  = 8,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgSelective,
  input  logic [TMO_W-1:0]  cfgTimeout,
  input  logic              inValid,
  input  logic [SEQ_W-1:0]  inSeq,
  input  logic              inCrcOk,
  input  logic [FLIT_W-1:0] inData,
  output logic              outValid,
  output logic [SEQ_W-1:0]  outSeq,
  output logic [FLIT_W-1:0] outData,
  output logic              reqValid,
  output logic [SEQ_W-1:0]  reqSeq,
  output logic              reqSelective
);

  strobe_t          strobe;
  logic [SEQ_W-1:0] expSeq, reqSeqNext;
  logic [DEPTH-1:0] heldValid;

  flit_replay_ctrl #(.SEQ_W(SEQ_W), .DEPTH(DEPTH), .TMO_W(TMO_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSeq(inSeq), .inCrcOk(inCrcOk),
    .cfgSelective(cfgSelective), .cfgTimeout(cfgTimeout), .heldValid(heldValid),
    .strobe(strobe), .expSeq(expSeq), .reqSeqNext(reqSeqNext)
  );

  flit_replay_dp #(.SEQ_W(SEQ_W), .FLIT_W(FLIT_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inSeq(inSeq), .inData(inData),
    .expSeq(expSeq), .reqSeqNext(reqSeqNext), .heldValid(heldValid),
    .outValid(outValid), .outSeq(outSeq), .outData(outData),
    .reqValid(reqValid), .reqSeq(reqSeq), .reqSelective(reqSelective)
  );

endmodule

// File: rtl/flit_replay_chk.sv
module flit_replay_chk
  import flit_replay_pkg::*;
#(
  parameter int SEQ_W = 10,
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inCrcOk,
  input logic             outValid,
  input logic [SEQ_W-1:0] outSeq,
  input logic             reqValid,
  input logic             reqSelective,
  input logic [DEPTH-1:0] heldValid,
  input strobe_t          strobe
);

  logic             haveLast;
  logic [SEQ_W-1:0] lastSeq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haveLast <= 1'b0;
      lastSeq  <= '0;
    end else if (outValid) begin
      haveLast <= 1'b1;
      lastSeq  <= outSeq;
    end
  end

  assert_first_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !haveLast) |-> (outSeq == '0));

  assert_in_order_R11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && haveLast) |-> (outSeq == lastSeq + SEQ_W'(1)));

  assert_bad_not_out_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inCrcOk && heldValid == '0) |=> !outValid);

  assert_one_source_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.passIn, strobe.popHead}));

  assert_gbn_empty_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqSelective) |-> (heldValid == '0));

  assert_no_store_flush_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.storeIn && strobe.flush));

endmodule

bind flit_replay_rx flit_replay_chk #(.SEQ_W(SEQ_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inCrcOk(inCrcOk),
  .outValid(outValid), .outSeq(outSeq), .reqValid(reqValid),
  .reqSelective(reqSelective), .heldValid(heldValid), .strobe(strobe)
);

// File: tb/flit_replay_rx_bench.sv
module flit_replay_rx_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SEQ_W  = 10;
  localparam int FLIT_W = 32;
  localparam int DEPTH  = 8;
  localparam int TMO_W  = 16;

  logic              clk = 1'b0;
  logic              rstN;
  logic              cfgSelective;
  logic [TMO_W-1:0]  cfgTimeout;
  logic              inValid;
  logic [SEQ_W-1:0]  inSeq;
  logic              inCrcOk;
  logic [FLIT_W-1:0] inData;
  logic              outValid;
  logic [SEQ_W-1:0]  outSeq;
  logic [FLIT_W-1:0] outData;
  logic              reqValid;
  logic [SEQ_W-1:0]  reqSeq;
  logic              reqSelective;

  int  checks   = 0;
  int  failures = 0;
  int  base     = 0;
  bit  finished = 0;

  flit_replay_rx #(.SEQ_W(SEQ_W), .FLIT_W(FLIT_W), .DEPTH(DEPTH), .TMO_W(TMO_W)) u_flit_replay_rx (
    .clk(clk), .rstN(rstN), .cfgSelective(cfgSelective), .cfgTimeout(cfgTimeout),
    .inValid(inValid), .inSeq(inSeq), .inCrcOk(inCrcOk), .inData(inData),
    .outValid(outValid), .outSeq(outSeq), .outData(outData),
    .reqValid(reqValid), .reqSeq(reqSeq), .reqSelective(reqSelective)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [FLIT_W-1:0] dataOf(input int seq);
    logic [SEQ_W-1:0] s;
    s = seq[SEQ_W-1:0];
    return {s, ~s, 12'hA5C};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input int seq, input bit ok);
    inValid = v;
    inSeq   = seq[SEQ_W-1:0];
    inCrcOk = ok;
    inData  = dataOf(seq);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic chkOut(input bit expV, input int seq, input string tag);
    check(outValid === expV, {tag, " outValid"}, int'(outValid), int'(expV));
    if (expV && outValid === 1'b1) begin
      check(outSeq == seq[SEQ_W-1:0], {tag, " outSeq"}, int'(outSeq), seq & 1023);
      check(outData == dataOf(seq), {tag, " outData"}, int'(outData), int'(dataOf(seq)));
    end
  endtask

  task automatic chkReq(input bit expV, input int seq, input bit sel, input string tag);
    check(reqValid === expV, {tag, " reqValid"}, int'(reqValid), int'(expV));
    if (expV && reqValid === 1'b1) begin
      check(reqSeq == seq[SEQ_W-1:0], {tag, " reqSeq"}, int'(reqSeq), seq & 1023);
      check(reqSelective == sel, {tag, " reqSelective"}, int'(reqSelective), int'(sel));
    end
  endtask

  task automatic t_reset();
    chkOut(0, 0, "R1 reset");
    chkReq(0, 0, 0, "R1 reset");
    step(1, 0, 1); chkOut(1, 0, "R1 first flit"); chkReq(0, 0, 0, "R1 first flit");
    base = 1;
  endtask

  task automatic t_inorder();
    for (int k = 0; k < 5; k++) begin
      step(1, base + k, 1); chkOut(1, base + k, "R2 in order");
    end
    step(0, 0, 0); chkOut(0, 0, "R2 idle");
    base += 5;
  endtask

  task automatic t_selective();
    cfgSelective = 1;
    step(1, base, 0); chkOut(0, 0, "R3 failed flit"); chkReq(1, base, 1, "R3 request");
    for (int k = 1; k <= 3; k++) begin
      step(1, base + k, 1); chkOut(0, 0, "R4 holding"); chkReq(0, 0, 0, "R4 holding");
    end
    step(1, base, 1); chkOut(1, base, "R4 replayed first");
    for (int k = 1; k <= 3; k++) begin
      step(0, 0, 0); chkOut(1, base + k, "R4 drain");
    end
    step(0, 0, 0); chkOut(0, 0, "R4 drain done");
    base += 4;
  endtask

  task automatic t_gbn();
    cfgSelective = 0;
    step(1, base, 0); chkOut(0, 0, "R3 gbn failed"); chkReq(1, base, 0, "R3 gbn request");
    step(1, base + 1, 1); chkOut(0, 0, "R5 dropped");
    step(1, base + 2, 1); chkOut(0, 0, "R5 dropped");
    step(1, base, 1); chkOut(1, base, "R5 replay");
    step(0, 0, 0); chkOut(0, 0, "R5 nothing held");
    step(1, base + 1, 1); chkOut(1, base + 1, "R5 resent");
    step(1, base + 2, 1); chkOut(1, base + 2, "R5 resent");
    base += 3;
  endtask

  task automatic t_dup();
    step(1, base - 1, 1); chkOut(0, 0, "R6 dup last"); chkReq(0, 0, 0, "R6 dup last");
    step(1, base - 3, 1); chkOut(0, 0, "R6 dup old"); chkReq(0, 0, 0, "R6 dup old");
    step(1, base, 1); chkOut(1, base, "R6 after dup");
    base += 1;
  endtask

  task automatic t_full();
    cfgSelective = 1;
    step(1, base, 0); chkReq(1, base, 1, "R7 start");
    for (int k = 1; k < DEPTH; k++) begin
      step(1, base + k, 1); chkOut(0, 0, "R7 fill");
    end
    step(1, base + DEPTH, 1); chkOut(0, 0, "R7 overflow"); chkReq(1, base, 0, "R7 fallback");
    step(1, base, 1); chkOut(1, base, "R7 replay");
    step(0, 0, 0); chkOut(0, 0, "R7 flushed");
    step(1, base + 1, 1); chkOut(1, base + 1, "R7 resent");
    base += 2;
  endtask

  task automatic t_second();
    cfgSelective = 1;
    step(1, base, 0); chkReq(1, base, 1, "R8 first fail");
    step(1, base + 1, 1); chkOut(0, 0, "R8 held");
    step(1, base + 2, 0); chkOut(0, 0, "R8 second fail"); chkReq(1, base, 0, "R8 fallback");
    step(1, base, 1); chkOut(1, base, "R8 replay");
    step(0, 0, 0); chkOut(0, 0, "R8 flushed");
    step(1, base + 1, 1); chkOut(1, base + 1, "R8 resent");
    base += 2;
  endtask

  task automatic t_timeout();
    cfgSelective = 1;
    cfgTimeout   = 6;
    step(1, base, 0); chkReq(1, base, 1, "R9 initial");
    for (int k = 1; k <= 5; k++) begin
      step(0, 0, 0); chkReq(0, 0, 0, "R9 waiting");
    end
    step(0, 0, 0); chkReq(1, base, 1, "R9 reissue");
    step(1, base, 1); chkOut(1, base, "R9 recovered");
    cfgTimeout = 200;
    base += 1;
  endtask

  task automatic t_ahead();
    cfgSelective = 0;
    step(1, base + 2, 1); chkOut(0, 0, "R10 ahead"); chkReq(1, base, 0, "R10 request");
    step(1, base, 1); chkOut(1, base, "R10 resent");
    step(1, base + 1, 1); chkOut(1, base + 1, "R10 resent");
    base += 2;
  endtask

  task automatic t_wrap();
    while ((base & 1023) != 1021) begin
      step(1, base, 1);
      base++;
    end
    for (int k = 0; k < 5; k++) begin
      step(1, base + k, 1); chkOut(1, base + k, "R6 wrap order");
    end
    base += 5;
    step(1, 1023, 1); chkOut(0, 0, "R6 wrap dup 1023");
    step(1, 1022, 1); chkOut(0, 0, "R6 wrap dup 1022");
  endtask

  task automatic t_random();
    int  nextSeq   = base;
    int  expOut    = base;
    int  delivered = 0;
    bit  pendValid = 0;
    int  pendSeq   = 0;
    int  pendDelay = 0;
    int  seq;
    bit  ok;
    cfgTimeout = 64;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (outValid) begin
        check(outSeq == expOut[SEQ_W-1:0] && outData == dataOf(expOut),
              "R11 random order", int'(outSeq), expOut & 1023);
        expOut++;
        delivered++;
      end
      if (reqValid) begin
        if (reqSelective) begin
          pendValid = 1;
          pendSeq   = int'(reqSeq);
          pendDelay = int'($urandom % 5);
        end else begin
          nextSeq   = (nextSeq & ~1023) + int'(reqSeq);
          if (nextSeq > expOut + 512) nextSeq -= 1024;
          if (nextSeq < expOut - 512) nextSeq += 1024;
          pendValid = 0;
        end
      end
      cfgSelective = ($urandom % 3) != 0;
      ok = !(cyc < 3500 && ($urandom % 10) == 0);
      if (pendValid && pendDelay == 0) begin
        pendValid = 0;
        step(1, pendSeq, ok);
      end else begin
        if (pendValid) pendDelay--;
        if (($urandom % 6) == 0) begin
          step(0, 0, 0);
        end else begin
          seq = nextSeq;
          nextSeq++;
          step(1, seq, ok);
        end
      end
    end
    check(delivered >= 1500, "R11 random progress", delivered, 1500);
    base = expOut;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 0; cfgSelective = 1; cfgTimeout = 200;
    inValid = 0; inSeq = '0; inCrcOk = 0; inData = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_inorder();
    t_selective();
    t_gbn();
    t_dup();
    t_full();
    t_second();
    t_timeout();
    t_ahead();
    t_wrap();
    t_random();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule